// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break Control

This block is the transmit half of a USART, reduced to asynchronous framing. A CPU-side write port places a character into a holding register. When the line is free, the character moves into a shift register and goes out on the serial output. The output carries a start bit (space), 5 to 8 data bits with the least significant bit first, an optional even or odd parity bit, and a stop period of 1, 1.5 or 2 bit times (mark). The holding register and the shift register are separate, so the CPU can write the next character while the current one is still on the line.

Bit timing comes from a transmit-clock enable pulse `txClkEn`. The block divides it by 1, 16 or 64 to get the bit period. `txEnable` decides whether new characters are accepted. Clearing it never truncates a frame on the line or a character that is already waiting in the holding register. `sendBreak` holds the line at space for as long as it is set. Two status outputs tell the CPU when it may write (`txRdy`) and when everything has drained (`txEmpty`).

Top module: `asyncTx`

## Requirements
- R1: While reset is held, `txd` is 1 and `txEmpty` is 1. At all times `txRdy` equals `txEnable` when the holding register is empty.
- R2: A frame is one start tick-group at 0, then `5 + charLen` data bits sent least significant bit first (charLen 00=5, 01=6, 10=7, 11=8 bits), then the stop period at 1. Only the low `5 + charLen` bits of the written byte are sent.
- R3: When `parityEn` is 1, a parity bit follows the data. It is the XOR of the sent data bits when `parityOdd` is 0, and the inverse of that XOR when `parityOdd` is 1. Bits above the configured length do not affect it.
- R4: Each bit lasts N pulses of `txClkEn`, where `baudSel` 00 gives N=1, 01 gives N=16, and 10 or 11 gives N=64. Cycles without a pulse do not advance the line.
- R5: The stop period lasts N pulses for `stopSel` 00, N + N/2 pulses for 01 (a single pulse when N=1), and 2N pulses for 10 or 11.
- R6: While `sendBreak` is 1, `txd` is 0 in the same cycle, whatever the frame state. Clearing it restores the normal line value.
- R7: When no frame is being sent and `sendBreak` is 0, `txd` is 1.
- R8: A write is taken into the holding register at the clock edge where `wrValid` and `txRdy` are both 1. If the line is idle, the start bit begins one cycle later. A character written during a frame starts on the tick that follows the previous stop period, with no idle gap.
- R9: `txRdy` is 1 exactly when the holding register is empty and `txEnable` is 1. It is 0 in the cycle after an accepted write. A write while `txRdy` is 0 is ignored.
- R10: `txEmpty` is 1 only when the holding register is empty and no frame is on the line. It is 0 from the accepted write until the end of the last stop period.
- R11: Clearing `txEnable` lets the frame in flight and any character already held finish in full. After that the line stays at mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| txClkEn | input | 1 | Transmit-clock enable pulse, one per tick |
| baudSel | input | 2 | Ticks per bit: 00=1, 01=16, 10/11=64 |
| charLen | input | 2 | Data bits minus five |
| stopSel | input | 2 | Stop period: 00=1, 01=1.5, 10/11=2 bits |
| parityEn | input | 1 | Append a parity bit |
| parityOdd | input | 1 | Odd parity when 1, even parity when 0 |
| txEnable | input | 1 | Permit new characters |
| sendBreak | input | 1 | Force the line to space |
| wrValid | input | 1 | Write strobe for `wrData` |
| wrData | input | 8 | Character to send |
| txd | output | 1 | Serial output, 1 is mark |
| txRdy | output | 1 | Holding register may be written |
| txEmpty | output | 1 | Holding and shift registers both empty |

## Verification
The bench sweeps every combination of character length, parity mode, stop setting and divider. For each one it compares the line against an arithmetically computed tick pattern, which catches a design that sends bits MSB first, leaks unused high bits into the data or parity, or times the half stop bit wrongly. Two back-to-back characters must appear on the line with no idle tick between them. A third write into the full holding register must vanish; a design that overwrote the register would send a wrong character. Dropping the enable mid-frame must still let the queued character go out; a design that stopped early would raise `txEmpty` too soon. Break asserted over data bits that are all 1, and a divider fed gapped enable pulses, show a design that ignores the break or counts clock cycles instead of pulses.

// File: rtl/asyncTxPkg.sv
package asyncTxPkg;
  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP} txState_e;
  typedef enum logic [1:0] {LN_MARK, LN_SPACE, LN_DATA, LN_PARITY} lineSel_e;
  typedef struct packed {
    logic     load;
    logic     shift;
    lineSel_e lineSel;
  } txStrobe_t;
endpackage

// File: rtl/asyncTxCtrl.sv
module asyncTxCtrl
  import asyncTxPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txClkEn,
  input  logic [1:0] baudSel,
  input  logic [1:0] charLen,
  input  logic [1:0] stopSel,
  input  logic       parityEn,
  input  logic       holdFull,
  output txStrobe_t  strobe,
  output logic       txIdle
);
  localparam int CNT_W   = $clog2(2 * DIV_HI) + 1;
  localparam int BIT_W   = $clog2(DATA_W);
  localparam int MIN_LEN = DATA_W - 3;

  txState_e         state;
  logic [CNT_W-1:0] tickCnt, bitTicks, stopTicks, limit;
  logic [BIT_W-1:0] bitCnt, lastIdx;
  logic             bitEnd;

  // ticks per bit and per stop period
  always_comb begin
    case (baudSel)
      2'd0:    bitTicks = CNT_W'(1);
      2'd1:    bitTicks = CNT_W'(DIV_MID);
      default: bitTicks = CNT_W'(DIV_HI);
    endcase
    case (stopSel)
      2'd0:    stopTicks = bitTicks;
      2'd1:    stopTicks = bitTicks + (bitTicks >> 1);
      default: stopTicks = bitTicks << 1;
    endcase
    limit = (state == ST_STOP) ? stopTicks : bitTicks;
  end

  assign lastIdx = BIT_W'(MIN_LEN - 1) + BIT_W'(charLen);
  assign bitEnd  = (state != ST_IDLE) && txClkEn && (tickCnt == limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (state == ST_IDLE) begin
      tickCnt <= '0;
      if (holdFull) state <= ST_START;
    end else if (txClkEn) begin
      if (bitEnd) begin
        tickCnt <= '0;
        case (state)
          ST_START: begin
            state  <= ST_DATA;
            bitCnt <= '0;
          end
          ST_DATA: begin
            if (bitCnt == lastIdx) state <= parityEn ? ST_PARITY : ST_STOP;
            else bitCnt <= bitCnt + BIT_W'(1);
          end
          ST_PARITY: state <= ST_STOP;
          default:   state <= holdFull ? ST_START : ST_IDLE;
        endcase
      end else begin
        tickCnt <= tickCnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    strobe.load  = holdFull && ((state == ST_IDLE) || (state == ST_STOP && bitEnd));
    strobe.shift = (state == ST_DATA) && bitEnd;
    case (state)
      ST_START:  strobe.lineSel = LN_SPACE;
      ST_DATA:   strobe.lineSel = LN_DATA;
      ST_PARITY: strobe.lineSel = LN_PARITY;
      default:   strobe.lineSel = LN_MARK;
    endcase
  end

  assign txIdle = (state == ST_IDLE);
endmodule

// File: rtl/asyncTxData.sv
module asyncTxData
  import asyncTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              txEnable,
  input  logic              parityOdd,
  input  logic [1:0]        charLen,
  input  logic              sendBreak,
  input  txStrobe_t         strobe,
  output logic              holdFull,
  output logic              txd
);
  localparam int MIN_LEN = DATA_W - 3;

  logic [DATA_W-1:0] holdReg, shiftReg, lenMask, maskedHold;
  logic              parityBit, wrAccept;

  // keep only the configured number of data bits
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign lenMask[i] = (i < MIN_LEN + int'(charLen));
  end

  assign maskedHold = holdReg & lenMask;
  assign wrAccept   = wrValid && txEnable && !holdFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg   <= '0;
      holdFull  <= 1'b0;
      shiftReg  <= '0;
      parityBit <= 1'b0;
    end else begin
      if (strobe.load) begin
        shiftReg  <= maskedHold;
        parityBit <= (^maskedHold) ^ parityOdd;
        holdFull  <= 1'b0;
      end else if (strobe.shift) begin
        shiftReg <= shiftReg >> 1;
      end
      if (wrAccept) begin
        holdReg  <= wrData;
        holdFull <= 1'b1;
      end
    end
  end

  always_comb begin
    if (sendBreak) txd = 1'b0;
    else begin
      case (strobe.lineSel)
        LN_SPACE:  txd = 1'b0;
        LN_DATA:   txd = shiftReg[0];
        LN_PARITY: txd = parityBit;
        default:   txd = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/asyncTx.sv
module asyncTx
  import asyncTxPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txClkEn,
  input  logic [1:0]        baudSel,
  input  logic [1:0]        charLen,
  input  logic [1:0]        stopSel,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              txEnable,
  input  logic              sendBreak,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  output logic              txd,
  output logic              txRdy,
  output logic              txEmpty
);
  txStrobe_t strobe;
  logic      holdFull, txIdle;

  asyncTxCtrl #(.DATA_W(DATA_W), .DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) ctrl (
    .clk(clk), .rstN(rstN), .txClkEn(txClkEn), .baudSel(baudSel), .charLen(charLen),
    .stopSel(stopSel), .parityEn(parityEn), .holdFull(holdFull), .strobe(strobe),
    .txIdle(txIdle)
  );

  asyncTxData #(.DATA_W(DATA_W)) data (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData), .txEnable(txEnable),
    .parityOdd(parityOdd), .charLen(charLen), .sendBreak(sendBreak), .strobe(strobe),
    .holdFull(holdFull), .txd(txd)
  );

  assign txRdy   = !holdFull && txEnable;
  assign txEmpty = !holdFull && txIdle;
endmodule

// File: rtl/asyncTxChecker.sv
module asyncTxChecker (
  input logic clk,
  input logic rstN,
  input logic wrValid,
  input logic txEnable,
  input logic sendBreak,
  input logic txd,
  input logic txRdy,
  input logic txEmpty
);
  p_break_space_r6: assert property (@(posedge clk) disable iff (!rstN)
    sendBreak |-> !txd);

  p_idle_mark_r7: assert property (@(posedge clk) disable iff (!rstN)
    (txEmpty && !sendBreak) |-> txd);

  p_rdy_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && txRdy) |=> !txRdy);

  p_rdy_needs_en_r9: assert property (@(posedge clk) disable iff (!rstN)
    txRdy |-> txEnable);

  p_write_fills_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && txRdy) |=> !txEmpty);

  p_empty_means_rdy_r1: assert property (@(posedge clk) disable iff (!rstN)
    (txEmpty && txEnable) |-> txRdy);
endmodule

bind asyncTx asyncTxChecker chk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .txEnable(txEnable),
  .sendBreak(sendBreak), .txd(txd), .txRdy(txRdy), .txEmpty(txEmpty)
);

// File: tb/asyncTx_test.sv
`timescale 1ns/1ps
module asyncTx_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txClkEn = 1'b0;
  logic [1:0] baudSel = 2'd0, charLen = 2'd3, stopSel = 2'd0;
  logic       parityEn = 1'b0, parityOdd = 1'b0;
  logic       txEnable = 1'b0, sendBreak = 1'b0, wrValid = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       txd, txRdy, txEmpty;
  int         checks = 0, fails = 0;

  always #5 clk = ~clk;

  asyncTx uut (
    .clk(clk), .rstN(rstN), .txClkEn(txClkEn), .baudSel(baudSel), .charLen(charLen),
    .stopSel(stopSel), .parityEn(parityEn), .parityOdd(parityOdd), .txEnable(txEnable),
    .sendBreak(sendBreak), .wrValid(wrValid), .wrData(wrData), .txd(txd),
    .txRdy(txRdy), .txEmpty(txEmpty)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int baudN();
    case (baudSel)
      2'd0: return 1;
      2'd1: return 16;
      default: return 64;
    endcase
  endfunction
  function automatic int lenB();
    return 5 + int'(charLen);
  endfunction
  function automatic int stopT();
    int n = baudN();
    case (stopSel)
      2'd0: return n;
      2'd1: return n + n / 2;
      default: return 2 * n;
    endcase
  endfunction
  function automatic int frameTicks();
    return (1 + lenB() + int'(parityEn)) * baudN() + stopT();
  endfunction
  function automatic logic expBit(input logic [7:0] d, input int j);
    int idx = j / baudN();
    logic p = 1'b0;
    if (idx == 0) return 1'b0;
    if (idx <= lenB()) return d[idx-1];
    if (parityEn && idx == lenB() + 1) begin
      for (int i = 0; i < lenB(); i++) p ^= d[i];
      return p ^ parityOdd;
    end
    return 1'b1;
  endfunction

  // write one character on an idle line; returns after the load edge
  task automatic writeChar(input logic [7:0] d);
    @(negedge clk);
    wrValid = 1'b1;
    wrData  = d;
    @(posedge clk);
    @(negedge clk);
    wrValid = 1'b0;
    #1;
    check(txRdy === 1'b0 && txEmpty === 1'b0, "R9", "txRdy/txEmpty after write",
          {txRdy, txEmpty}, 0);
    @(posedge clk);
  endtask

  // follow one frame tick by tick; the frame started at the previous edge
  task automatic runFrame(input logic [7:0] d, input bit qNext, input logic [7:0] nd,
                          input bit extraWr, input bit dropEn, input bit brk,
                          input int gap, input string req);
    int mism = 0, firstJ = -1, actB = 0, expB = 0, emptyBad = 0, rdyBad = 0;
    int total = frameTicks();
    for (int j = 0; j < total; j++) begin
      for (int g = 0; g < gap; g++) begin
        logic e;
        @(negedge clk);
        txClkEn = (g == gap - 1);
        wrValid = 1'b0;
        if (qNext && j == 0 && g == 0) begin wrValid = 1'b1; wrData = nd; end
        if (extraWr && j == 3 && g == 0) begin wrValid = 1'b1; wrData = 8'h00; end
        if (dropEn && j == 2) txEnable = 1'b0;
        if (brk) sendBreak = (j >= 2 && j < 5);
        #1;
        e = sendBreak ? 1'b0 : expBit(d, j);
        if (j == 0 && g == 0 && txRdy !== txEnable) rdyBad++;
        if (txEmpty !== 1'b0) emptyBad++;
        if (txd !== e) begin
          if (firstJ < 0) begin firstJ = j; actB = txd; expB = e; end
          mism++;
        end
        @(posedge clk);
      end
    end
    check(mism == 0, req, $sformatf("line bit at tick %0d of frame %h", firstJ, d), actB, expB);
    check(emptyBad == 0, "R10", "txEmpty high during frame", emptyBad, 0);
    check(rdyBad == 0, "R9", "txRdy at frame start", rdyBad, 0);
  endtask

  task automatic idleCheck(input string req);
    @(negedge clk);
    txClkEn = 1'b0;
    wrValid = 1'b0;
    #1;
    check(txd === 1'b1 && txEmpty === 1'b1, req, "idle line/txEmpty after frames",
          {txd, txEmpty}, 3);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL all: watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    int iter = 0;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(txd === 1'b1 && txEmpty === 1'b1 && txRdy === 1'b0, "R1", "reset outputs",
          {txd, txEmpty, txRdy}, 6);
    rstN = 1'b1;
    txEnable = 1'b1;
    @(negedge clk);
    #1;
    check(txRdy === 1'b1, "R1", "txRdy after enable", txRdy, 1);

    // R2 R3 R4 R5: full configuration sweep, one pulse per cycle
    for (int b = 0; b < 3; b++)
      for (int l = 0; l < 4; l++)
        for (int p = 0; p < 3; p++)
          for (int s = 0; s < 3; s++) begin
            logic [7:0] d = 8'hA5 ^ 8'(iter * 37);
            iter++;
            @(negedge clk);
            baudSel = 2'(b); charLen = 2'(l); stopSel = 2'(s);
            parityEn = (p != 0); parityOdd = (p == 2);
            writeChar(d);
            runFrame(d, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1, "R2/R3/R4/R5");
            idleCheck("R7");
          end

    // R4: gapped enable pulses at 16x, odd parity, 1.5 stop bits
    @(negedge clk);
    baudSel = 2'd1; charLen = 2'd3; stopSel = 2'd1; parityEn = 1'b1; parityOdd = 1'b1;
    writeChar(8'h3C);
    runFrame(8'h3C, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 3, "R4");
    idleCheck("R7");

    // R8: back-to-back characters; third write into a full holder is ignored (R9)
    @(negedge clk);
    baudSel = 2'd0; charLen = 2'd3; stopSel = 2'd0; parityEn = 1'b0;
    writeChar(8'h96);
    runFrame(8'h96, 1'b1, 8'h4B, 1'b1, 1'b0, 1'b0, 1, "R8");
    runFrame(8'h4B, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1, "R8");
    idleCheck("R9");

    // R11: enable dropped mid-frame with a character queued
    @(negedge clk);
    baudSel = 2'd1; stopSel = 2'd2;
    writeChar(8'hC3);
    runFrame(8'hC3, 1'b1, 8'h5A, 1'b0, 1'b1, 1'b0, 1, "R11");
    runFrame(8'h5A, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1, "R11");
    idleCheck("R11");
    check(txRdy === 1'b0, "R9", "txRdy with enable low", txRdy, 0);
    @(negedge clk);
    wrValid = 1'b1; wrData = 8'h00;
    @(negedge clk);
    wrValid = 1'b0;
    begin
      int bad = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        txClkEn = 1'b1;
        #1;
        if (txd !== 1'b1 || txEmpty !== 1'b1) bad++;
      end
      check(bad == 0, "R9", "write while disabled reached the line", bad, 0);
    end
    @(negedge clk);
    txClkEn = 1'b0; txEnable = 1'b1;
    #1;
    check(txRdy === 1'b1 && txEmpty === 1'b1, "R9", "txRdy after re-enable",
          {txRdy, txEmpty}, 3);

    // R6: break while idle and over data bits that are all ones
    @(negedge clk);
    sendBreak = 1'b1;
    #1;
    check(txd === 1'b0, "R6", "break on idle line", txd, 0);
    @(negedge clk);
    sendBreak = 1'b0;
    #1;
    check(txd === 1'b1, "R6", "line after break cleared", txd, 1);
    baudSel = 2'd0; stopSel = 2'd0;
    writeChar(8'hFF);
    runFrame(8'hFF, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1, "R6");
    idleCheck("R7");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule